// File: doc/BRIEF.md
# Load-Store Ordering Unit

This block tracks memory operations between dispatch and completion and decides whether a queued operation may issue under conservative ordering. Loads and stores go into separate queues, each with its own capacity. An operation that both reads and writes memory takes one entry in each queue. Every operation is named by a 5-bit program-order tag. Age is the tag minus an oldest-in-flight pointer, taken modulo 32, which gives a window of up to 16 operations.

The pipeline dispatches an operation with its load, store and side-effect flags. It can ask whether a candidate operation would stall on a full queue. It can also ask whether an operation already in a queue may issue now, and it retires operations through a completion port. Operations with side effects act as barriers for the queues they use. A mode input lets loads bypass the store-ordering rules when the addresses are known not to overlap. Each queue is a bit vector indexed by tag. Oldest-entry finders scan that vector, starting from the age pointer.

Top module: `lsq_order_unit`

## Requirements
- R1: Load capacity and store capacity are separate parameters (defaults 4 and 4). A dispatch with both flags set takes one entry in each queue.
- R2: `avail_code` is registered one cycle after the query and reflects the state before that edge. Code 1 means the load queue is full and the query asks for a load. Code 2 means the store queue is full and the query asks for a store. Code 0 means neither applies. Code 1 wins over code 2.
- R3: A dispatch with `disp_bar` set records a load barrier if it loads and a store barrier if it stores.
- R4: A load whose age exceeds that of the oldest load barrier is not ready. A load that is itself the oldest load barrier is ready only if it is also the oldest queued load. Stores obey the same rules against store barriers and the store queue.
- R5: With `noalias_en` high, a load that passes R4 is ready.
- R6: Otherwise, an operation whose age exceeds that of the oldest queued store is not ready.
- R7: An operation not blocked by R4 or R6 is ready if the load queue is empty or if its age is at most that of the oldest queued load.
- R8: If older loads are still queued, a load is ready and a store is not.
- R9: Completion removes the tag from both queues. A barrier record is cleared only when the completing tag is the oldest barrier of that kind; otherwise the record stays and keeps blocking.
- R10: Every age is (tag − `age_base`) mod 32. Dispatched tags lie less than 16 ahead of `age_base`.
- R11: A dispatch into a full needed queue, or with a tag already present in either queue, sets `err_sticky` and changes no state. Only reset clears `err_sticky`.
- R12: `rdy_ok` is registered one cycle after `rdy_tag` is presented. It is 0 for a tag that is in neither queue.
- R13: After reset both queues and both barrier sets are empty, and `avail_code`, `rdy_ok` and `err_sticky` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| age_base | input | 5 | Tag of the oldest in-flight operation; origin for ages |
| noalias_en | input | 1 | Loads ignore store ordering |
| disp_valid | input | 1 | Dispatch strobe |
| disp_tag | input | 5 | Tag being dispatched |
| disp_ld | input | 1 | Dispatched operation reads memory |
| disp_st | input | 1 | Dispatched operation writes memory |
| disp_bar | input | 1 | Dispatched operation has side effects |
| chk_ld | input | 1 | Stall query: candidate reads memory |
| chk_st | input | 1 | Stall query: candidate writes memory |
| avail_code | output | 2 | Stall answer: 0 free, 1 load queue full, 2 store queue full |
| rdy_tag | input | 5 | Tag whose readiness is asked |
| rdy_ok | output | 1 | Readiness answer |
| cmp_valid | input | 1 | Completion strobe |
| cmp_tag | input | 5 | Tag being retired |
| err_sticky | output | 1 | Illegal dispatch seen since reset |

## Verification
Dispatch and completion take effect at the edge that samples them. `avail_code` and `rdy_ok` are registered from the state held before the edge, so a query presented in the cycle after a dispatch or completion already sees its effect, one edge later. The bench drives every stimulus just after a falling edge and reads the answers at the next falling edge. It never sends a query in the same cycle as a state change. The expected answer is computed from a bench model of the queues, updated in the same order. `err_sticky` is read one falling edge after the bad dispatch.

// File: rtl/lsq_pkg.sv
package lsq_pkg;
  typedef enum logic [1:0] {
    AV_OK      = 2'd0,
    AV_LQ_FULL = 2'd1,
    AV_SQ_FULL = 2'd2
  } avail_e;
endpackage

// File: rtl/lsq_oldest.sv
// Finds the entry closest to base, scanning upward with wrap-around.
module lsq_oldest #(
  parameter int IDX_W = 5,
  localparam int N = 1 << IDX_W
) (
  input  logic [N-1:0]     occ,
  input  logic [IDX_W-1:0] base,
  output logic             found,
  output logic [IDX_W-1:0] age
);
  logic [IDX_W-1:0] k;
  always_comb begin
    found = 1'b0;
    age   = '0;
    k     = '0;
    for (int i = N - 1; i >= 0; i--) begin
      k = base + IDX_W'(i);
      if (occ[k]) begin
        found = 1'b1;
        age   = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/lsq_ready.sv
// Ordering rules for one queued operation; all ages relative to the same base.
module lsq_ready #(
  parameter int AGE_W = 5
) (
  input  logic             is_ld,
  input  logic             is_st,
  input  logic [AGE_W-1:0] q_age,
  input  logic             noalias,
  input  logic             ld_any,
  input  logic [AGE_W-1:0] ld_age,
  input  logic             st_any,
  input  logic [AGE_W-1:0] st_age,
  input  logic             lb_any,
  input  logic [AGE_W-1:0] lb_age,
  input  logic             sb_any,
  input  logic [AGE_W-1:0] sb_age,
  output logic             ready
);
  logic ld_fence, st_fence;

  // Barrier gates (R4)
  assign ld_fence = is_ld && lb_any &&
                    ((q_age > lb_age) || (q_age == lb_age && q_age != ld_age));
  assign st_fence = is_st && sb_any &&
                    ((q_age > sb_age) || (q_age == sb_age && q_age != st_age));

  always_comb begin
    if (!(is_ld || is_st) || ld_fence || st_fence)
      ready = 1'b0;
    else if (noalias && is_ld)
      ready = 1'b1;
    else if (st_any && q_age > st_age)
      ready = 1'b0;
    else if (!ld_any || q_age <= ld_age)
      ready = 1'b1;
    else
      ready = !is_st;
  end
endmodule

// File: rtl/lsq_order_unit.sv
module lsq_order_unit #(
  parameter int TAG_W    = 5,
  parameter int WIN      = 16,
  parameter int LQ_DEPTH = 4,
  parameter int SQ_DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [TAG_W-1:0] age_base,
  input  logic             noalias_en,
  input  logic             disp_valid,
  input  logic [TAG_W-1:0] disp_tag,
  input  logic             disp_ld,
  input  logic             disp_st,
  input  logic             disp_bar,
  input  logic             chk_ld,
  input  logic             chk_st,
  output logic [1:0]       avail_code,
  input  logic [TAG_W-1:0] rdy_tag,
  output logic             rdy_ok,
  input  logic             cmp_valid,
  input  logic [TAG_W-1:0] cmp_tag,
  output logic             err_sticky
);
  import lsq_pkg::*;

  localparam int NTAG  = 1 << TAG_W;
  localparam int MAXD  = (LQ_DEPTH > SQ_DEPTH) ? LQ_DEPTH : SQ_DEPTH;
  localparam int CW    = $clog2(MAXD + 1);
  localparam int NFIND = 4;  // load, store, load barrier, store barrier

  logic [NTAG-1:0] ld_occ, st_occ, lb_occ, sb_occ;
  logic [NTAG-1:0] ld_n, st_n, lb_n, sb_n;
  logic [CW-1:0]   ld_cnt, st_cnt, ldc_n, stc_n;

  logic [NTAG-1:0]  occ_v [NFIND];
  logic [NFIND-1:0] fnd;
  logic [TAG_W-1:0] oage  [NFIND];

  assign occ_v[0] = ld_occ;
  assign occ_v[1] = st_occ;
  assign occ_v[2] = lb_occ;
  assign occ_v[3] = sb_occ;

  for (genvar g = 0; g < NFIND; g++) begin : g_find
    lsq_oldest #(.IDX_W(TAG_W)) u_old (
      .occ  (occ_v[g]),
      .base (age_base),
      .found(fnd[g]),
      .age  (oage[g])
    );
  end

  logic [TAG_W-1:0] cmp_age, disp_age, q_age;
  logic             lq_full, sq_full, dup, disp_any, disp_ok, disp_bad;
  logic             rdy_c;

  assign cmp_age  = cmp_tag - age_base;
  assign disp_age = disp_tag - age_base;
  assign q_age    = rdy_tag - age_base;
  assign lq_full  = (ld_cnt == CW'(LQ_DEPTH));
  assign sq_full  = (st_cnt == CW'(SQ_DEPTH));
  assign dup      = ld_occ[disp_tag] | st_occ[disp_tag];
  assign disp_any = disp_valid && (disp_ld || disp_st);
  assign disp_bad = disp_any && (dup || (disp_ld && lq_full) || (disp_st && sq_full));
  assign disp_ok  = disp_any && !disp_bad;

  always_comb begin
    ld_n  = ld_occ;
    st_n  = st_occ;
    lb_n  = lb_occ;
    sb_n  = sb_occ;
    ldc_n = ld_cnt;
    stc_n = st_cnt;
    if (cmp_valid) begin
      if (ld_occ[cmp_tag]) begin
        ld_n[cmp_tag] = 1'b0;
        ldc_n         = ldc_n - CW'(1);
      end
      if (st_occ[cmp_tag]) begin
        st_n[cmp_tag] = 1'b0;
        stc_n         = stc_n - CW'(1);
      end
      if (fnd[2] && cmp_age == oage[2]) lb_n[cmp_tag] = 1'b0;
      if (fnd[3] && cmp_age == oage[3]) sb_n[cmp_tag] = 1'b0;
    end
    if (disp_ok) begin
      if (disp_ld) begin
        ld_n[disp_tag] = 1'b1;
        ldc_n          = ldc_n + CW'(1);
        if (disp_bar) lb_n[disp_tag] = 1'b1;
      end
      if (disp_st) begin
        st_n[disp_tag] = 1'b1;
        stc_n          = stc_n + CW'(1);
        if (disp_bar) sb_n[disp_tag] = 1'b1;
      end
    end
  end

  lsq_ready #(.AGE_W(TAG_W)) u_rdy (
    .is_ld  (ld_occ[rdy_tag]),
    .is_st  (st_occ[rdy_tag]),
    .q_age  (q_age),
    .noalias(noalias_en),
    .ld_any (fnd[0]),
    .ld_age (oage[0]),
    .st_any (fnd[1]),
    .st_age (oage[1]),
    .lb_any (fnd[2]),
    .lb_age (oage[2]),
    .sb_any (fnd[3]),
    .sb_age (oage[3]),
    .ready  (rdy_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ld_occ     <= '0;
      st_occ     <= '0;
      lb_occ     <= '0;
      sb_occ     <= '0;
      ld_cnt     <= '0;
      st_cnt     <= '0;
      avail_code <= AV_OK;
      rdy_ok     <= 1'b0;
      err_sticky <= 1'b0;
    end else begin
      ld_occ <= ld_n;
      st_occ <= st_n;
      lb_occ <= lb_n;
      sb_occ <= sb_n;
      ld_cnt <= ldc_n;
      st_cnt <= stc_n;
      if (chk_ld && lq_full)      avail_code <= AV_LQ_FULL;
      else if (chk_st && sq_full) avail_code <= AV_SQ_FULL;
      else                        avail_code <= AV_OK;
      rdy_ok <= rdy_c;
      if (disp_bad) err_sticky <= 1'b1;
    end
  end

  // R1
  lq_bound_chk: assert property (@(posedge clk) disable iff (rst)
    (ld_cnt <= CW'(LQ_DEPTH)) && ($countones(ld_occ) == int'(ld_cnt)));
  // R1
  sq_bound_chk: assert property (@(posedge clk) disable iff (rst)
    (st_cnt <= CW'(SQ_DEPTH)) && ($countones(st_occ) == int'(st_cnt)));
  // R2
  avail_lq_chk: assert property (@(posedge clk) disable iff (rst)
    (avail_code == AV_LQ_FULL) |-> ($past(chk_ld) && $past(ld_cnt) == CW'(LQ_DEPTH)));
  // R11
  err_hold_chk: assert property (@(posedge clk) disable iff (rst)
    err_sticky |=> err_sticky);
  // R11
  dup_nochange_chk: assert property (@(posedge clk) disable iff (rst)
    (disp_any && dup && !cmp_valid) |=> ($stable(ld_occ) && $stable(st_occ) && err_sticky));
  // R12
  rdy_queued_chk: assert property (@(posedge clk) disable iff (rst)
    rdy_ok |-> $past(ld_occ[rdy_tag] | st_occ[rdy_tag]));
  // R10
  window_chk: assert property (@(posedge clk) disable iff (rst)
    disp_valid |-> (int'(disp_age) < WIN));
endmodule

// File: tb/lsq_order_unit_tb_top.sv
`timescale 1ns/1ps
module lsq_order_unit_tb_top;
  localparam int LQ = 4;
  localparam int SQ = 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [4:0] age_base = '0;
  logic       noalias_en = 1'b0;
  logic       disp_valid = 1'b0, disp_ld = 1'b0, disp_st = 1'b0, disp_bar = 1'b0;
  logic [4:0] disp_tag = '0, rdy_tag = '0, cmp_tag = '0;
  logic       chk_ld = 1'b0, chk_st = 1'b0, cmp_valid = 1'b0;
  logic [1:0] avail_code;
  logic       rdy_ok, err_sticky;

  always #10 clk = ~clk;

  lsq_order_unit #(.LQ_DEPTH(LQ), .SQ_DEPTH(SQ)) dut_i (
    .clk(clk), .rst(rst), .age_base(age_base), .noalias_en(noalias_en),
    .disp_valid(disp_valid), .disp_tag(disp_tag), .disp_ld(disp_ld),
    .disp_st(disp_st), .disp_bar(disp_bar), .chk_ld(chk_ld), .chk_st(chk_st),
    .avail_code(avail_code), .rdy_tag(rdy_tag), .rdy_ok(rdy_ok),
    .cmp_valid(cmp_valid), .cmp_tag(cmp_tag), .err_sticky(err_sticky));

  int checks = 0, errors = 0;
  bit done = 0;
  int base = 0, next_tag = 0;
  bit [31:0] m_ld, m_st, m_lb, m_sb;
  int m_lc, m_sc;
  bit m_err;
  logic [15:0] lf = 16'hACE1;

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int agef(int t);
    return (t - base) & 31;
  endfunction

  function automatic int old_age(bit [31:0] v);
    for (int i = 0; i < 32; i++) if (v[(base + i) & 31]) return i;
    return -1;
  endfunction

  function automatic bit ref_ready(int t);
    int a = agef(t);
    int la = old_age(m_ld), sa = old_age(m_st);
    int lba = old_age(m_lb), sba = old_age(m_sb);
    bit il = m_ld[t], is = m_st[t];
    if (!(il || is)) return 0;
    if (il && lba >= 0 && (a > lba || (a == lba && a != la))) return 0;
    if (is && sba >= 0 && (a > sba || (a == sba && a != sa))) return 0;
    if (noalias_en && il) return 1;
    if (sa >= 0 && a > sa) return 0;
    if (la < 0 || a <= la) return 1;
    return !is;
  endfunction

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    tick(); tick();
    rst = 1'b0;
    m_ld = '0; m_st = '0; m_lb = '0; m_sb = '0;
    m_lc = 0; m_sc = 0; m_err = 0;
  endtask

  task automatic set_base(int b);
    base = b & 31;
    age_base = 5'(base);
  endtask

  task automatic dispatch(int t, bit l, bit s, bit b);
    disp_valid = 1'b1; disp_tag = 5'(t); disp_ld = l; disp_st = s; disp_bar = b;
    tick();
    disp_valid = 1'b0; disp_ld = 1'b0; disp_st = 1'b0; disp_bar = 1'b0;
    if (l || s) begin
      if ((m_ld[t] | m_st[t]) || (l && m_lc == LQ) || (s && m_sc == SQ)) m_err = 1;
      else begin
        if (l) begin m_ld[t] = 1; m_lc++; if (b) m_lb[t] = 1; end
        if (s) begin m_st[t] = 1; m_sc++; if (b) m_sb[t] = 1; end
      end
    end
  endtask

  task automatic complete(int t);
    int lba = old_age(m_lb), sba = old_age(m_sb);
    cmp_valid = 1'b1; cmp_tag = 5'(t);
    tick();
    cmp_valid = 1'b0;
    if (m_ld[t]) begin m_ld[t] = 0; m_lc--; end
    if (m_st[t]) begin m_st[t] = 0; m_sc--; end
    if (lba >= 0 && agef(t) == lba) m_lb[t] = 0;
    if (sba >= 0 && agef(t) == sba) m_sb[t] = 0;
  endtask

  task automatic check_rdy(string req, int t);
    rdy_tag = 5'(t);
    tick();
    check(req, int'(rdy_ok), int'(ref_ready(t)));
  endtask

  task automatic check_avail(string req, bit l, bit s);
    int exp;
    chk_ld = l; chk_st = s;
    tick();
    chk_ld = 1'b0; chk_st = 1'b0;
    exp = (l && m_lc == LQ) ? 1 : ((s && m_sc == SQ) ? 2 : 0);
    check(req, int'(avail_code), exp);
  endtask

  task automatic sweep_avail(string req);
    for (int q = 1; q < 4; q++) check_avail(req, q[0], q[1]);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    do_reset();
    // R13 reset state
    tick();
    check("R13 avail", int'(avail_code), 0);
    check("R13 rdy", int'(rdy_ok), 0);
    check("R13 err", int'(err_sticky), 0);
    check_rdy("R12 empty", 0);

    // R1 / R2: load+store operations fill both queues together
    set_base(0);
    for (int t = 0; t < 4; t++) begin
      dispatch(t, 1, 1, 0);
      sweep_avail("R1 R2 fill both");
    end
    check_avail("R2 load full first", 1, 1);
    for (int t = 0; t < 4; t++) begin
      check_rdy("R7 R8 mixed", t);
      complete(t);
    end
    sweep_avail("R9 drained");
    set_base(4);
    for (int t = 4; t < 8; t++) begin
      dispatch(t, 1, 0, 0);
      sweep_avail("R1 loads only");
    end
    // R11: dispatch into a full load queue is rejected
    dispatch(8, 1, 0, 0);
    check("R11 err full", int'(err_sticky), 1);
    check_rdy("R11 R12 rejected tag", 8);
    sweep_avail("R11 unchanged");
    tick();
    check("R11 sticky", int'(err_sticky), 1);
    do_reset();

    // R11: duplicate tag store rejected; younger load stays ready
    set_base(0);
    dispatch(1, 1, 0, 0);
    dispatch(1, 0, 1, 0);
    check("R11 err dup", int'(err_sticky), 1);
    dispatch(2, 1, 0, 0);
    check_rdy("R11 R8 no store added", 2);
    check("R11 expect ready", int'(ref_ready(2)), 1);
    do_reset();

    // R3 R4 R9: barrier rules, including a stale record
    set_base(0);
    dispatch(0, 1, 0, 0);
    dispatch(1, 1, 0, 1);
    dispatch(2, 1, 0, 0);
    check_rdy("R7 oldest load", 0);
    check_rdy("R4 barrier not oldest load", 1);
    check_rdy("R4 younger than barrier", 2);
    complete(0);
    check_rdy("R4 barrier now oldest", 1);
    check_rdy("R4 still behind barrier", 2);
    dispatch(3, 1, 0, 1);
    complete(3);
    complete(1);
    check_rdy("R9 older than stale barrier", 2);
    dispatch(4, 1, 0, 0);
    check_rdy("R9 stale barrier blocks", 4);
    check("R9 expect blocked", int'(ref_ready(4)), 0);
    dispatch(5, 0, 1, 1);
    dispatch(6, 0, 1, 0);
    check_rdy("R8 store behind loads", 5);
    check_rdy("R3 R4 younger than store barrier", 6);
    noalias_en = 1'b1;
    check_rdy("R5 barrier still applies", 4);
    noalias_en = 1'b0;
    do_reset();

    // R5 R6: no-alias lets a load pass an older store
    set_base(0);
    dispatch(0, 0, 1, 0);
    dispatch(1, 1, 0, 0);
    check_rdy("R6 load behind store", 1);
    noalias_en = 1'b1;
    check_rdy("R5 no-alias load", 1);
    check_rdy("R5 store unaffected", 0);
    noalias_en = 1'b0;
    do_reset();

    // R10: ages across the tag wrap
    set_base(28);
    dispatch(28, 1, 0, 0);
    dispatch(30, 0, 1, 0);
    dispatch(0, 1, 0, 0);
    dispatch(1, 0, 1, 0);
    for (int t = 28; t < 34; t++) check_rdy("R10 wrap", t & 31);
    do_reset();

    // Sweep: long program-order stream with mixed flags
    set_base(0);
    next_tag = 0;
    for (int it = 0; it < 400; it++) begin
      int span = (next_tag - base) & 31;
      int kind;
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      if (it % 60 == 30) noalias_en = ~noalias_en;
      kind = (lf[1:0] == 2'd0) ? 3 : ((lf[1:0] == 2'd1) ? 1 : 2);
      if (lf[4:2] != 3'd0 && span < 15 &&
          !((kind[0] && m_lc == LQ) || (kind[1] && m_sc == SQ))) begin
        dispatch(next_tag, kind[0], kind[1], lf[7:6] == 2'd0);
        next_tag = (next_tag + 1) & 31;
      end else if ((m_ld | m_st) != 0) begin
        int pick = -1, cnt = 0;
        for (int i = 0; i < 16; i++) begin
          int t = (base + i) & 31;
          if ((m_ld[t] | m_st[t]) && ref_ready(t)) begin
            if (cnt == 0 || lf[8 + (cnt % 4)]) pick = t;
            cnt++;
          end
        end
        if (pick >= 0) complete(pick);
        if ((m_ld | m_st) != 0) set_base(base + old_age(m_ld | m_st));
        else set_base(next_tag);
      end
      for (int i = 0; i < 16; i++) begin
        int t = (base + i) & 31;
        if (m_ld[t] | m_st[t]) check_rdy("R4 R6 R7 R8 R10 sweep", t);
      end
      if (it % 8 == 0) check_rdy("R12 not queued", next_tag);
      if (it % 5 == 0) sweep_avail("R2 sweep");
    end
    check("R11 no error in sweep", int'(err_sticky), int'(m_err));
    finish_run();
  end
endmodule